// File: doc/BRIEF.md
# Cascadable Four-Channel Countdown Timer Group

This block holds four down-counting timers behind a small word-addressed register port. A single prescaler, shared by all four, divides the input clock by 8, 16, 32 or 64 and produces one count tick per period. Each timer has a base register and a current-count register. Bit 31 of the base register stops the timer. A running timer counts down once per tick. On the tick after it reaches zero, it reloads from its base and raises a pending flag. That flag drives the timer's active-low interrupt until software writes a one to clear it.

Neighbouring timers can be joined into one longer counter. The lower timer counts a full 32-bit value. The higher timer steps down once each time the lower one wraps, and it owns the stop bit and the interrupt of the pair. A per-pair rollover bit decides what happens when the pair expires. With the bit set, the pair reloads and runs periodically. With it clear, the pair halts at zero until its higher base register is written again. Software writes the joining and rollover bits of a pair together.

Top module: `qtg_timer_group`

## Requirements
- R1: After reset, every base register reads 0x8000_0000 (stopped), every current count and the control and status words read zero, and all four irq_n outputs are high.
- R2: Control bits 9:8 choose the tick period in clocks: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 64.
- R3: Writing a base register also loads that timer's current count, using the low 31 bits for a timer that is not the lower half of a pair. While bit 31 of the base is set, the current count holds its value.
- R4: A running unpaired timer with base N counts down one step per tick. On the tick at zero it reloads N and sets its pending flag, so it expires every (N+1) ticks.
- R5: The status word at address 1 shows the pending flags in bits 3:0. Writing a one to bit i clears flag i, a new expiry in the same cycle takes precedence, and irq_n[i] is low exactly while flag i is set.
- R6: Control bits 0, 1 and 2 join timers (0,1), (1,2) and (2,3). When two requested pairs overlap, the lower-numbered pair wins, and the remaining timer runs unpaired.
- R7: In a pair, the lower timer keeps a full 32-bit count. When it is at zero on a tick, it reloads from its own base and the higher timer steps down. The pair expires every (a+1)(b+1) ticks for lower base a and higher base b. Only the higher timer raises an interrupt. Writing the higher base with bit 31 clear starts the pair and reloads both counts.
- R8: Control bits 24, 25 and 26 are the rollover bits of the three pairs. With the bit clear, an expired pair stays at zero and raises no further interrupt until its higher base is written again.
- R9: Any write to a current-count register sets that count to zero.
- R10: Writing the higher base of a pair with bit 31 set clears the current counts of both timers of that pair.
- R11: Word addresses: 0 is control, 1 is status, 2+2i is base i and 3+2i is current count i. Control bits outside 26:24, 9:8 and 2:0 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr | input | 4 | Word address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_n | output | 4 | Per-timer active-low interrupt levels |

## Verification
A register write takes effect at the clock edge that samples it. Because the read port is combinational, the value written is readable from the next falling edge onward. A pending flag shows on irq_n in the cycle after the tick that sets it. For this reason the bench drives and samples only at falling edges, and it reads current counts right after a load, before any later tick can move them. Tick phase is never predicted. Each period is measured as the cycle distance between two successive interrupt assertions, with the flag cleared between them. For a single timer that distance must equal (N+1) times the divide ratio, and for a pair it must equal (a+1)(b+1) times the divide ratio.

// File: rtl/qtg_pkg.sv
package qtg_pkg;
  // control word field positions
  localparam int unsigned CHAIN_LSB = 0;
  localparam int unsigned SEL_LSB   = 8;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned ROLL_LSB  = 24;
  // minimum prescale ratio is 2**MIN_LOG2
  localparam int unsigned MIN_LOG2  = 3;

  // word address map
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned CH_ADDR0  = 2;

  function automatic int unsigned base_addr(input int unsigned ch);
    return CH_ADDR0 + 2 * ch;
  endfunction

  function automatic int unsigned cur_addr(input int unsigned ch);
    return CH_ADDR0 + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/qtg_prescaler.sv
module qtg_prescaler #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned MIN_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned CNT_W = MIN_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = CNT_W'((32'd1 << (MIN_LOG2 + 32'(sel))) - 32'd1);
    tick  = (cnt_q >= limit);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a tick never repeats on the next clock (smallest ratio is 8)
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/qtg_pairing.sv
module qtg_pairing #(
  parameter int unsigned NCH = 4
) (
  input  logic           tick,
  input  logic [NCH-2:0] chain_req,
  input  logic [NCH-2:0] roll_req,
  input  logic [NCH-1:0] stop,
  input  logic [NCH-1:0] spent,
  input  logic [NCH-1:0] zero,
  output logic [NCH-1:0] lower_of,
  output logic [NCH-1:0] upper_of,
  output logic [NCH-1:0] cnt_en,
  output logic [NCH-1:0] hold
);
  localparam int unsigned NP = NCH - 1;

  logic [NP-1:0]  eff;
  logic [NCH-1:0] run;

  // overlapping requests: lower-numbered pair takes precedence
  always_comb begin
    eff[0] = chain_req[0];
    for (int p = 1; p < NP; p++) eff[p] = chain_req[p] & ~eff[p-1];
  end

  assign run = ~stop & ~spent;

  for (genvar i = 0; i < NCH; i++) begin : g_role
    logic lo_b, up_b, run_hi, zero_hi, zero_lo, roll_lo, roll_up;

    if (i < NCH - 1) begin : g_has_hi
      assign lo_b    = eff[i];
      assign run_hi  = run[i+1];
      assign zero_hi = zero[i+1];
      assign roll_lo = roll_req[i];
    end else begin : g_no_hi
      assign lo_b    = 1'b0;
      assign run_hi  = 1'b0;
      assign zero_hi = 1'b0;
      assign roll_lo = 1'b0;
    end

    if (i > 0) begin : g_has_lo
      assign up_b    = eff[i-1];
      assign zero_lo = zero[i-1];
      assign roll_up = roll_req[i-1];
    end else begin : g_no_lo
      assign up_b    = 1'b0;
      assign zero_lo = 1'b0;
      assign roll_up = 1'b0;
    end

    assign lower_of[i] = lo_b;
    assign upper_of[i] = up_b;
    assign cnt_en[i]   = tick & (lo_b ? run_hi
                                      : (up_b ? (run[i] & zero_lo) : run[i]));
    assign hold[i]     = lo_b ? (~roll_lo & zero_hi) : (up_b & ~roll_up);
  end
endmodule

// File: rtl/qtg_channel.sv
module qtg_channel #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [DW-1:0] wdata,
  input  logic          cur_clr,
  input  logic          cur_ld,
  input  logic          wide,
  input  logic          en,
  input  logic          hold,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] cur_q,
  output logic          zero,
  output logic          wrap,
  output logic          spent
);
  localparam logic [DW-1:0] STOP_RST = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] NARROW   = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] base_d, cur_d, mask, src;
  logic          spent_d;

  always_comb begin
    mask   = wide ? '1 : NARROW;
    src    = base_we ? wdata : base_q;
    zero   = (cur_q == '0);
    wrap   = en & zero;
    base_d = src;

    if (cur_clr)     cur_d = '0;
    else if (cur_ld) cur_d = src & mask;
    else if (en)     cur_d = zero ? (hold ? '0 : (base_q & mask)) : cur_q - 1'b1;
    else             cur_d = cur_q;

    if (base_we)            spent_d = 1'b0;
    else if (wrap && hold)  spent_d = 1'b1;
    else                    spent_d = spent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= STOP_RST;
      cur_q  <= '0;
      spent  <= 1'b0;
    end else begin
      base_q <= base_d;
      cur_q  <= cur_d;
      spent  <= spent_d;
    end
  end

  // R4: a counting step lowers the count by exactly one
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !zero && !cur_clr && !cur_ld) |=> (cur_q == $past(cur_q) - 1'b1));

  // R3: without a count enable or a write the count does not move
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cur_clr && !cur_ld) |=> $stable(cur_q));

  // R9: a clear request leaves the count at zero
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_clr |=> (cur_q == '0));
endmodule

// File: rtl/qtg_timer_group.sv
module qtg_timer_group #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NCH-1:0] irq_n
);
  import qtg_pkg::*;

  localparam int unsigned NP = NCH - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // control and status state
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [NP-1:0]    chain_q, chain_d, roll_q, roll_d;
  logic [NCH-1:0]   pend_q, pend_d;
  logic             ctrl_we, stat_we, tick;

  logic [DW-1:0]  base_q [NCH];
  logic [DW-1:0]  cur_q  [NCH];
  logic [NCH-1:0] base_we, cur_we, stop_v, zero_v, spent_v, wrap_v;
  logic [NCH-1:0] cnt_en, hold, lower_of, upper_of;
  logic [NCH-1:0] stop_wr, start_wr, cur_clr, cur_ld, evt;

  assign ctrl_we = bus_we && (bus_addr == AW'(CTRL_ADDR));
  assign stat_we = bus_we && (bus_addr == AW'(STAT_ADDR));

  always_comb begin
    sel_d   = ctrl_we ? bus_wdata[SEL_LSB +: SEL_W]  : sel_q;
    chain_d = ctrl_we ? bus_wdata[CHAIN_LSB +: NP]   : chain_q;
    roll_d  = ctrl_we ? bus_wdata[ROLL_LSB +: NP]    : roll_q;
    evt     = wrap_v & ~lower_of;
    pend_d  = (pend_q & ~(stat_we ? bus_wdata[NCH-1:0] : '0)) | evt;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sel_q   <= '0;
      chain_q <= '0;
      roll_q  <= '0;
      pend_q  <= '0;
    end else begin
      sel_q   <= sel_d;
      chain_q <= chain_d;
      roll_q  <= roll_d;
      pend_q  <= pend_d;
    end
  end

  qtg_prescaler #(.SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2)) u_presc (
    .clk   (clk),
    .rst_n (rst_i),
    .sel   (sel_q),
    .tick  (tick)
  );

  qtg_pairing #(.NCH(NCH)) u_pairing (
    .tick      (tick),
    .chain_req (chain_q),
    .roll_req  (roll_q),
    .stop      (stop_v),
    .spent     (spent_v),
    .zero      (zero_v),
    .lower_of  (lower_of),
    .upper_of  (upper_of),
    .cnt_en    (cnt_en),
    .hold      (hold)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic lo_stop, lo_start;

    assign base_we[i]  = bus_we && (bus_addr == AW'(base_addr(i)));
    assign cur_we[i]   = bus_we && (bus_addr == AW'(cur_addr(i)));
    assign stop_wr[i]  = base_we[i] & upper_of[i] &  bus_wdata[DW-1];
    assign start_wr[i] = base_we[i] & upper_of[i] & ~bus_wdata[DW-1];

    if (i < NCH - 1) begin : g_lo_ctl
      assign lo_stop  = lower_of[i] & stop_wr[i+1];
      assign lo_start = lower_of[i] & start_wr[i+1];
    end else begin : g_no_lo_ctl
      assign lo_stop  = 1'b0;
      assign lo_start = 1'b0;
    end

    assign cur_clr[i] = cur_we[i] | stop_wr[i] | lo_stop;
    assign cur_ld[i]  = base_we[i] | lo_start;
    assign stop_v[i]  = base_q[i][DW-1];

    qtg_channel #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_i),
      .base_we (base_we[i]),
      .wdata   (bus_wdata),
      .cur_clr (cur_clr[i]),
      .cur_ld  (cur_ld[i]),
      .wide    (lower_of[i]),
      .en      (cnt_en[i]),
      .hold    (hold[i]),
      .base_q  (base_q[i]),
      .cur_q   (cur_q[i]),
      .zero    (zero_v[i]),
      .wrap    (wrap_v[i]),
      .spent   (spent_v[i])
    );

    // R5: a clear with no new expiry releases the interrupt line
    assert_irq_release_R5: assert property (@(posedge clk) disable iff (!rst_i)
      (stat_we && bus_wdata[i] && !evt[i]) |=> irq_n[i]);

    // R6: a timer is never both halves of pairs at once
    assert_role_excl_R6: assert property (@(posedge clk) disable iff (!rst_i)
      !(lower_of[i] && upper_of[i]));

    // R8: a halted pair produces no expiry until re-armed
    assert_spent_quiet_R8: assert property (@(posedge clk) disable iff (!rst_i)
      (upper_of[i] && spent_v[i]) |-> !evt[i]);

    if (i > 0) begin : g_pair_chk
      // R10: stopping the higher half empties both counts
      assert_pair_stop_R10: assert property (@(posedge clk) disable iff (!rst_i)
        stop_wr[i] |=> (cur_q[i] == '0 && cur_q[i-1] == '0));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(CTRL_ADDR)) begin
      bus_rdata[SEL_LSB +: SEL_W] = sel_q;
      bus_rdata[CHAIN_LSB +: NP]  = chain_q;
      bus_rdata[ROLL_LSB +: NP]   = roll_q;
    end
    if (bus_addr == AW'(STAT_ADDR)) bus_rdata[NCH-1:0] = pend_q;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(base_addr(i))) bus_rdata = base_q[i];
      if (bus_addr == AW'(cur_addr(i)))  bus_rdata = cur_q[i];
    end
  end

  assign irq_n = ~pend_q;
endmodule

// File: tb/test_qtg_timer_group.sv
module test_qtg_timer_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_n;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  qtg_timer_group i_qtg_timer_group (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic        cas;
    logic [1:0]  ch;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [15:0] period;
  } vec_t;

  // expected period in clocks: (N+1)*div, or (a+1)*(b+1)*div for a pair
  localparam vec_t VEC [8] = '{
    '{32'h0000_0000, 1'b0, 2'd0, 32'd0, 32'd3, 16'd32},   // R4 R2 div 8
    '{32'h0000_0100, 1'b0, 2'd1, 32'd0, 32'd5, 16'd96},   // R2 div 16
    '{32'h0000_0200, 1'b0, 2'd2, 32'd0, 32'd2, 16'd96},   // R2 div 32
    '{32'h0000_0300, 1'b0, 2'd3, 32'd0, 32'd1, 16'd128},  // R2 div 64
    '{32'h0100_0001, 1'b1, 2'd1, 32'd2, 32'd1, 16'd48},   // R7 pair 0-1
    '{32'h0200_0002, 1'b1, 2'd2, 32'd3, 32'd2, 16'd96},   // R7 pair 1-2
    '{32'h0400_0104, 1'b1, 2'd3, 32'd0, 32'd3, 16'd64},   // R7 pair 2-3
    '{32'h0000_0003, 1'b0, 2'd2, 32'd0, 32'd4, 16'd40}    // R6 overlap
  };

  function automatic logic [3:0] a_base(input int ch);
    return 4'(2 + 2 * ch);
  endfunction
  function automatic logic [3:0] a_cur(input int ch);
    return 4'(3 + 2 * ch);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // callers stand at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic wait_irq(input int ch, input int lim, output bit hit, output int unsigned at);
    hit = 1'b0; at = 0;
    for (int k = 0; k < lim && !hit; k++) begin
      if (irq_n[ch] === 1'b0) begin hit = 1'b1; at = cyc; end
      else @(negedge clk);
    end
  endtask

  task automatic idle_all();
    for (int c = 0; c < 4; c++) wr(a_base(c), 32'h8000_0000);
    wr(4'd1, 32'hF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, d2;
    bit hit;
    int unsigned t1, t2;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq_n", {28'd0, irq_n}, 32'hF);
    rd(4'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'd1, d); chk("R1 status", d, 32'h0);
    rd(a_base(0), d); chk("R1 base0", d, 32'h8000_0000);
    rd(a_base(3), d); chk("R1 base3", d, 32'h8000_0000);
    rd(a_cur(2), d);  chk("R1 cur2", d, 32'h0);

    // R11 control field layout
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d); chk("R11 ctrl mask", d, 32'h0700_0307);
    wr(4'd0, 32'h0);

    // R3 stop bit holds count, load takes low 31 bits
    wr(a_base(1), 32'h8000_0009);
    rd(a_cur(1), d); chk("R3 load masked", d, 32'd9);
    repeat (200) @(negedge clk);
    rd(a_cur(1), d); chk("R3 stopped holds", d, 32'd9);
    rd(a_base(1), d); chk("R11 base readback", d, 32'h8000_0009);

    // R9 current write clears
    wr(a_cur(1), 32'h1234_5678);
    rd(a_cur(1), d); chk("R9 cur cleared", d, 32'd0);

    // R7 lower half holds full 32 bits, R10 pair stop clears both
    wr(4'd0, 32'h0100_0001);
    wr(a_base(0), 32'h8000_0005);
    wr(a_base(1), 32'h0000_0007);
    rd(a_cur(0), d);  chk("R7 lower wide load", d, 32'h8000_0005);
    rd(a_cur(1), d2); chk("R7 upper load", d2, 32'd7);
    repeat (100) @(negedge clk);
    rd(a_cur(0), d);
    chk("R7 lower counts", {31'd0, (d < 32'h8000_0005 && d >= 32'h8000_0005 - 14)}, 32'd1);
    wr(a_base(1), 32'h8000_0007);
    rd(a_cur(0), d);  chk("R10 lower cleared", d, 32'd0);
    rd(a_cur(1), d);  chk("R10 upper cleared", d, 32'd0);
    idle_all();

    // R8 pair without rollover halts after one expiry
    wr(4'd0, 32'h0000_0001);
    wr(a_base(0), 32'd1);
    wr(a_base(1), 32'd1);
    wait_irq(1, 100, hit, t1);
    chk("R8 first expiry", {31'd0, hit}, 32'd1);
    wr(4'd1, 32'h2);
    repeat (150) @(negedge clk);
    chk("R8 no second irq", {31'd0, irq_n[1]}, 32'd1);
    rd(a_cur(0), d); chk("R8 lower at zero", d, 32'd0);
    rd(a_cur(1), d); chk("R8 upper at zero", d, 32'd0);
    wr(a_base(1), 32'd1);
    wait_irq(1, 100, hit, t1);
    chk("R8 re-armed", {31'd0, hit}, 32'd1);
    idle_all();
    wr(4'd0, 32'h0);

    // R5 selective clear of pending flags
    wr(a_base(2), 32'd3);
    wr(a_base(3), 32'd3);
    repeat (100) @(negedge clk);
    wr(a_base(2), 32'h8000_0003);
    wr(a_base(3), 32'h8000_0003);
    rd(4'd1, d); chk("R5 both pending", d, 32'hC);
    wr(4'd1, 32'h4);
    rd(4'd1, d); chk("R5 clear bit2 only", d, 32'h8);
    chk("R5 irq lines", {28'd0, irq_n}, 32'h7);
    wr(4'd1, 32'h8);
    chk("R5 all released", {28'd0, irq_n}, 32'hF);

    // table of period vectors
    foreach (VEC[v]) begin
      idle_all();
      wr(4'd0, VEC[v].ctrl);
      if (VEC[v].cas) wr(a_base(int'(VEC[v].ch) - 1), VEC[v].lo);
      wr(a_base(int'(VEC[v].ch)), VEC[v].hi);
      wait_irq(int'(VEC[v].ch), 4 * int'(VEC[v].period) + 100, hit, t1);
      wr(4'd1, 32'h1 << VEC[v].ch);
      wait_irq(int'(VEC[v].ch), 4 * int'(VEC[v].period) + 100, hit, t2);
      chk(VEC[v].cas ? "R7 pair period" : "R4 R2 R6 period",
          hit ? t2 - t1 : 32'hFFFF_FFFF, {16'd0, VEC[v].period});
      if (VEC[v].cas) begin
        rd(4'd1, d);
        chk("R7 lower silent", {31'd0, d[VEC[v].ch - 2'd1]}, 32'd0);
      end
    end
    idle_all();

    finish_run();
  end
endmodule